// File: doc/BRIEF.md
# Interrupt Presenter with Inter-Processor Request

This block sits between one interrupt source unit and one processor. It keeps a 32-bit status word that holds the processor's current priority threshold in the top byte and the number of the pending source in the low 24 bits, where a zero source field means nothing is pending. It also keeps the priority of the pending source and a software-written inter-processor request level. A lower priority number is more favoured throughout.

The source unit offers interrupts with a priority and a source number. The presenter takes or refuses each one. A refused offer, or a pending device source that a better offer or a register write displaces, goes back to the source unit as a one-cycle reject pulse with its number. Software uses a small register port. It can take the pending interrupt (read and clear), peek at the word, set the threshold, set the inter-processor level, and signal end of service. End-of-service and resend requests go to the source unit as one-cycle pulses. The inter-processor request shares the pending slot with device interrupts and uses source number 2.

Top module: `irq_presenter`

## Requirements
- R1: After reset the status word reads 0x00000000, the interrupt line is low, and the pending priority and the inter-processor level are both 0xff. Because the threshold is 0, every offer is refused.
- R2: An offer of priority p is refused when p is not below the threshold, or when a source is pending whose priority is at or below p. A refused offer gives one reject pulse on the offer reject port, carrying the offer's number, one cycle later, and leaves the line unchanged.
- R3: A taken offer latches its number and priority and raises the line. If the source it displaces came from a device, that source's number is rejected on the offer reject port. A displaced inter-processor request is not rejected.
- R4: Writing the inter-processor level (reg_op 4, value in bits 7:0) with a value below the threshold runs the inter-processor check. The check does nothing if a source is pending with priority at or below the level. Otherwise it rejects a pending device source on the write reject port, loads source 2 with the level as its pending priority, and raises the line.
- R5: A take-read (reg_op 1) returns the status word and lowers the line. It then reloads the word with the old pending priority as threshold and source 0, and sets the pending priority to 0xff.
- R6: A peek-read (reg_op 2) returns the status word and changes no state or output.
- R7: A threshold write (reg_op 3, value in bits 7:0) with a more favoured value checks the pending source. If one is pending and the new value is at or below its priority, the source field is cleared, the pending priority becomes 0xff, the line drops, and a device source is rejected on the write reject port.
- R8: A threshold write that is not more favoured, made while nothing is pending, first runs the inter-processor check if the level is below the new threshold, then gives one resend pulse.
- R9: An end-of-service write (reg_op 5) copies bits 31:24 into the threshold and pulses eoi_valid with bits 23:0. If nothing is pending afterwards, it acts as in R8: the inter-processor check when the level is below the threshold, then a resend pulse.
- R10: An offer in the same cycle as a register operation is judged against the state left by that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| offer_valid | input | 1 | Source unit offers an interrupt this cycle |
| offer_prio | input | 8 | Priority of the offer |
| offer_src | input | 24 | Source number of the offer |
| reg_op | input | 3 | 0 idle, 1 take-read, 2 peek-read, 3 threshold write, 4 inter-processor write, 5 end-of-service write |
| reg_wdata | input | 32 | Write data |
| rd_data | output | 32 | Status word during read operations, else zero |
| irq_out | output | 1 | Interrupt line to the processor |
| off_rej_valid | output | 1 | Reject pulse caused by an offer |
| off_rej_src | output | 24 | Source number of that reject |
| wr_rej_valid | output | 1 | Reject pulse caused by a register write |
| wr_rej_src | output | 24 | Source number of that reject |
| resend_req | output | 1 | Resend request pulse to the source unit |
| eoi_valid | output | 1 | End-of-service pulse to the source unit |
| eoi_src | output | 24 | Source number for end-of-service |

## Verification
The hardest situation to reach is an end-of-service write that refills the pending slot with the inter-processor request. It needs a level that was stored below a later threshold, a take-read that emptied the slot, and an end-of-service write that raises the threshold past the level. The stimulus gets there through a take-read followed by a threshold-raising end-of-service write. It then checks the resend pulse, the line and a follow-up peek. Same-cycle write and offer pairs are driven where the order changes the result.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
    parameter int SRC_W  = 24;
    parameter int PRIO_W = 8;
    localparam int WORD_W = SRC_W + PRIO_W;
    localparam logic [PRIO_W-1:0] PRIO_LEAST = '1;

    typedef enum logic [2:0] {
        OP_IDLE = 3'd0,
        OP_TAKE = 3'd1,
        OP_PEEK = 3'd2,
        OP_THR  = 3'd3,
        OP_IPL  = 3'd4,
        OP_DONE = 3'd5
    } reg_op_e;

    typedef struct packed {
        logic [PRIO_W-1:0] thr;
        logic [SRC_W-1:0]  src;
        logic [PRIO_W-1:0] pend;
        logic [PRIO_W-1:0] ipl;
        logic              dev_own;
        logic              irq;
        logic              wrej_v;
        logic [SRC_W-1:0]  wrej_src;
        logic              orej_v;
        logic [SRC_W-1:0]  orej_src;
        logic              resend;
        logic              eoi_v;
        logic [SRC_W-1:0]  eoi_src;
    } pres_t;

    // Inter-processor check: claim the pending slot unless a better source holds it
    function automatic pres_t ipl_probe(pres_t s, logic [SRC_W-1:0] ipi_num);
        pres_t r;
        r = s;
        if (!(s.src != '0 && s.pend <= s.ipl)) begin
            if (s.src != '0 && s.dev_own) begin
                r.wrej_v   = 1'b1;
                r.wrej_src = s.src;
            end
            r.src     = ipi_num;
            r.pend    = s.ipl;
            r.dev_own = 1'b0;
            r.irq     = 1'b1;
        end
        return r;
    endfunction
endpackage

// File: rtl/irqp_offer_judge.sv
module irqp_offer_judge
    import irqp_pkg::*;
(
    input  logic [PRIO_W-1:0] thr,
    input  logic [SRC_W-1:0]  cur_src,
    input  logic [PRIO_W-1:0] cur_pend,
    input  logic [PRIO_W-1:0] prio,
    output logic              take
);
    logic occupied;

    always_comb begin
        occupied = (cur_src != '0);
        take     = (prio < thr) && !(occupied && (cur_pend <= prio));
    end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
    import irqp_pkg::*;
#(
    parameter logic [SRC_W-1:0] IPI_SRC = 24'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              offer_valid,
    input  logic [PRIO_W-1:0] offer_prio,
    input  logic [SRC_W-1:0]  offer_src,
    input  logic [2:0]        reg_op,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] rd_data,
    output logic              irq_out,
    output logic              off_rej_valid,
    output logic [SRC_W-1:0]  off_rej_src,
    output logic              wr_rej_valid,
    output logic [SRC_W-1:0]  wr_rej_src,
    output logic              resend_req,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_src
);
    localparam pres_t RESET_STATE = '{
        thr: '0, src: '0, pend: PRIO_LEAST, ipl: PRIO_LEAST,
        dev_own: 1'b0, irq: 1'b0, wrej_v: 1'b0, wrej_src: '0,
        orej_v: 1'b0, orej_src: '0, resend: 1'b0, eoi_v: 1'b0, eoi_src: '0
    };

    pres_t   st_q, mid_d, st_d;
    reg_op_e op;
    logic    offer_take;
    logic [PRIO_W-1:0] wr_byte;

    assign op      = reg_op_e'(reg_op);
    assign wr_byte = reg_wdata[PRIO_W-1:0];

    // Stage 1: register operation applied to the held state
    always_comb begin
        mid_d          = st_q;
        mid_d.wrej_v   = 1'b0;
        mid_d.wrej_src = '0;
        mid_d.orej_v   = 1'b0;
        mid_d.orej_src = '0;
        mid_d.resend   = 1'b0;
        mid_d.eoi_v    = 1'b0;
        mid_d.eoi_src  = '0;
        case (op)
            OP_TAKE: begin
                mid_d.irq     = 1'b0;
                mid_d.thr     = st_q.pend;
                mid_d.src     = '0;
                mid_d.pend    = PRIO_LEAST;
                mid_d.dev_own = 1'b0;
            end
            OP_THR: begin
                mid_d.thr = wr_byte;
                if (wr_byte < st_q.thr) begin
                    if (st_q.src != '0 && wr_byte <= st_q.pend) begin
                        if (st_q.dev_own) begin
                            mid_d.wrej_v   = 1'b1;
                            mid_d.wrej_src = st_q.src;
                        end
                        mid_d.src     = '0;
                        mid_d.pend    = PRIO_LEAST;
                        mid_d.irq     = 1'b0;
                        mid_d.dev_own = 1'b0;
                    end
                end else if (st_q.src == '0) begin
                    if (st_q.ipl < wr_byte) mid_d = ipl_probe(mid_d, IPI_SRC);
                    mid_d.resend = 1'b1;
                end
            end
            OP_IPL: begin
                mid_d.ipl = wr_byte;
                if (wr_byte < st_q.thr) mid_d = ipl_probe(mid_d, IPI_SRC);
            end
            OP_DONE: begin
                mid_d.thr     = reg_wdata[WORD_W-1:SRC_W];
                mid_d.eoi_v   = 1'b1;
                mid_d.eoi_src = reg_wdata[SRC_W-1:0];
                if (st_q.src == '0) begin
                    if (st_q.ipl < reg_wdata[WORD_W-1:SRC_W]) mid_d = ipl_probe(mid_d, IPI_SRC);
                    mid_d.resend = 1'b1;
                end
            end
            default: ;
        endcase
    end

    irqp_offer_judge u_judge (
        .thr      (mid_d.thr),
        .cur_src  (mid_d.src),
        .cur_pend (mid_d.pend),
        .prio     (offer_prio),
        .take     (offer_take)
    );

    // Stage 2: offer judged after the register operation
    always_comb begin
        st_d = mid_d;
        if (offer_valid) begin
            if (offer_take) begin
                if (mid_d.src != '0 && mid_d.dev_own) begin
                    st_d.orej_v   = 1'b1;
                    st_d.orej_src = mid_d.src;
                end
                st_d.src     = offer_src;
                st_d.pend    = offer_prio;
                st_d.dev_own = 1'b1;
                st_d.irq     = 1'b1;
            end else begin
                st_d.orej_v   = 1'b1;
                st_d.orej_src = offer_src;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RESET_STATE;
        else        st_q <= st_d;
    end

    assign rd_data       = (op == OP_TAKE || op == OP_PEEK) ? {st_q.thr, st_q.src} : '0;
    assign irq_out       = st_q.irq;
    assign off_rej_valid = st_q.orej_v;
    assign off_rej_src   = st_q.orej_src;
    assign wr_rej_valid  = st_q.wrej_v;
    assign wr_rej_src    = st_q.wrej_src;
    assign resend_req    = st_q.resend;
    assign eoi_valid     = st_q.eoi_v;
    assign eoi_src       = st_q.eoi_src;

    AST_OFFER_REJ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        off_rej_valid |-> $past(offer_valid)); // R2
    AST_LINE_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (st_q.src != '0)); // R3
    AST_TAKE_DROPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_TAKE && !offer_valid) |=> !irq_out); // R5
    AST_PEEK_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PEEK && !offer_valid) |=> ($stable(st_q.thr) && $stable(st_q.src) && $stable(irq_out))); // R6
    AST_WR_REJ_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rej_valid |-> (wr_rej_src != '0)); // R7
    AST_EOI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> $past(reg_op == 3'd5)); // R9
endmodule

// File: tb/sim_irq_presenter.sv
module sim_irq_presenter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        offer_valid = 1'b0;
    logic [7:0]  offer_prio = '0;
    logic [23:0] offer_src = '0;
    logic [2:0]  reg_op = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] rd_data;
    logic        irq_out, off_rej_valid, wr_rej_valid, resend_req, eoi_valid;
    logic [23:0] off_rej_src, wr_rej_src, eoi_src;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_presenter u0 (
        .clk(clk), .rst_n(rst_n), .offer_valid(offer_valid), .offer_prio(offer_prio),
        .offer_src(offer_src), .reg_op(reg_op), .reg_wdata(reg_wdata), .rd_data(rd_data),
        .irq_out(irq_out), .off_rej_valid(off_rej_valid), .off_rej_src(off_rej_src),
        .wr_rej_valid(wr_rej_valid), .wr_rej_src(wr_rej_src), .resend_req(resend_req),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src)
    );

    typedef struct packed {
        logic [2:0]  op;  logic [31:0] wd;
        logic        ov;  logic [7:0]  pr;  logic [23:0] os;
        logic [31:0] rd;  logic        irq;
        logic        orv; logic [23:0] ors;
        logic        wrv; logic [23:0] wrs;
        logic        rs;  logic        ev;  logic [23:0] es;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t V [NV] = '{
        '{3'd2,32'h0,1'b0,8'h00,24'h0, 32'h00000000,1'b0, 1'b0,24'h0, 1'b0,24'h0, 1'b0,1'b0,24'h0, 4'd6},  // R6 R1 peek after reset
        '{3'd3,32'hff,1'b0,8'h00,24'h0, 32'h0,1'b0, 1'b0,24'h0, 1'b0,24'h0, 1'b1,1'b0,24'h0, 4'd8},        // R8 open threshold
        '{3'd0,32'h0,1'b1,8'h05,24'h10, 32'h0,1'b1, 1'b0,24'h0, 1'b0,24'h0, 1'b0,1'b0,24'h0, 4'd3},        // R3 take
        '{3'd0,32'h0,1'b1,8'h05,24'h11, 32'h0,1'b1, 1'b1,24'h11, 1'b0,24'h0, 1'b0,1'b0,24'h0, 4'd2},       // R2 equal pending refused
        '{3'd0,32'h0,1'b1,8'h03,24'h12, 32'h0,1'b1, 1'b1,24'h10, 1'b0,24'h0, 1'b0,1'b0,24'h0, 4'd3},       // R3 displace device
        '{3'd2,32'h0,1'b0,8'h00,24'h0, 32'hff000012,1'b1, 1'b0,24'h0, 1'b0,24'h0, 1'b0,1'b0,24'h0, 4'd6},  // R6
        '{3'd4,32'h04,1'b0,8'h00,24'h0, 32'h0,1'b1, 1'b0,24'h0, 1'b0,24'h0, 1'b0,1'b0,24'h0, 4'd4},        // R4 better pending holds
        '{3'd4,32'h02,1'b0,8'h00,24'h0, 32'h0,1'b1, 1'b0,24'h0, 1'b1,24'h12, 1'b0,1'b0,24'h0, 4'd4},       // R4 IPI displaces
        '{3'd1,32'h0,1'b0,8'h00,24'h0, 32'hff000002,1'b0, 1'b0,24'h0, 1'b0,24'h0, 1'b0,1'b0,24'h0, 4'd5},  // R5 take-read
        '{3'd0,32'h0,1'b1,8'h02,24'h20, 32'h0,1'b0, 1'b1,24'h20, 1'b0,24'h0, 1'b0,1'b0,24'h0, 4'd2},       // R2 not below threshold
        '{3'd5,32'hff000002,1'b0,8'h00,24'h0, 32'h0,1'b1, 1'b0,24'h0, 1'b0,24'h0, 1'b1,1'b1,24'h2, 4'd9},  // R9 eoi refills IPI
        '{3'd2,32'h0,1'b0,8'h00,24'h0, 32'hff000002,1'b1, 1'b0,24'h0, 1'b0,24'h0, 1'b0,1'b0,24'h0, 4'd9},  // R9
        '{3'd0,32'h0,1'b1,8'h01,24'h30, 32'h0,1'b1, 1'b0,24'h0, 1'b0,24'h0, 1'b0,1'b0,24'h0, 4'd3},        // R3 IPI displaced silently
        '{3'd3,32'h01,1'b0,8'h00,24'h0, 32'h0,1'b0, 1'b0,24'h0, 1'b1,24'h30, 1'b0,1'b0,24'h0, 4'd7},       // R7
        '{3'd2,32'h0,1'b0,8'h00,24'h0, 32'h01000000,1'b0, 1'b0,24'h0, 1'b0,24'h0, 1'b0,1'b0,24'h0, 4'd7},  // R7
        '{3'd4,32'hff,1'b0,8'h00,24'h0, 32'h0,1'b0, 1'b0,24'h0, 1'b0,24'h0, 1'b0,1'b0,24'h0, 4'd4},        // R4 not below
        '{3'd3,32'h80,1'b0,8'h00,24'h0, 32'h0,1'b0, 1'b0,24'h0, 1'b0,24'h0, 1'b1,1'b0,24'h0, 4'd8},        // R8
        '{3'd3,32'h10,1'b1,8'h20,24'h40, 32'h0,1'b0, 1'b1,24'h40, 1'b0,24'h0, 1'b0,1'b0,24'h0, 4'd10},     // R10 write first
        '{3'd4,32'h05,1'b1,8'h03,24'h41, 32'h0,1'b1, 1'b0,24'h0, 1'b0,24'h0, 1'b0,1'b0,24'h0, 4'd10},      // R10
        '{3'd2,32'h0,1'b0,8'h00,24'h0, 32'h10000041,1'b1, 1'b0,24'h0, 1'b0,24'h0, 1'b0,1'b0,24'h0, 4'd10}, // R10
        '{3'd1,32'h0,1'b0,8'h00,24'h0, 32'h10000041,1'b0, 1'b0,24'h0, 1'b0,24'h0, 1'b0,1'b0,24'h0, 4'd5},  // R5
        '{3'd5,32'h10000041,1'b0,8'h00,24'h0, 32'h0,1'b1, 1'b0,24'h0, 1'b0,24'h0, 1'b1,1'b1,24'h41, 4'd9}, // R9
        '{3'd2,32'h0,1'b0,8'h00,24'h0, 32'h10000002,1'b1, 1'b0,24'h0, 1'b0,24'h0, 1'b0,1'b0,24'h0, 4'd8}   // R8 IPI via resend
    };

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    logic [31:0] rd_seen;

    task automatic step(input logic [2:0] op, input logic [31:0] wd, input logic ov,
                        input logic [7:0] pr, input logic [23:0] os);
        @(negedge clk);
        reg_op = op; reg_wdata = wd; offer_valid = ov; offer_prio = pr; offer_src = os;
        #3 rd_seen = rd_data;
        @(posedge clk);
        #1;
        reg_op = '0; offer_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R1", "irq after reset", {31'b0, irq_out}, 32'h0);
        for (int i = 0; i < NV; i++) begin
            string t;
            t = $sformatf("R%0d vec%0d", V[i].req, i);
            step(V[i].op, V[i].wd, V[i].ov, V[i].pr, V[i].os);
            chk(t, "rd_data", rd_seen, V[i].rd);
            chk(t, "irq", {31'b0, irq_out}, {31'b0, V[i].irq});
            chk(t, "off_rej", {7'b0, off_rej_valid, off_rej_src}, {7'b0, V[i].orv, V[i].ors});
            chk(t, "wr_rej", {7'b0, wr_rej_valid, wr_rej_src}, {7'b0, V[i].wrv, V[i].wrs});
            chk(t, "resend", {31'b0, resend_req}, {31'b0, V[i].rs});
            chk(t, "eoi", {7'b0, eoi_valid, eoi_src}, {7'b0, V[i].ev, V[i].es});
        end
        // R1: reset in the middle of activity
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R1", "irq after mid reset", {31'b0, irq_out}, 32'h0);
        step(3'd2, 32'h0, 1'b0, 8'h0, 24'h0);
        chk("R1", "word after reset", rd_seen, 32'h0);
        step(3'd0, 32'h0, 1'b1, 8'h00, 24'h5);
        chk("R1", "offer refused at threshold 0", {7'b0, off_rej_valid, off_rej_src}, {7'b0, 1'b1, 24'h5});
        chk("R1", "irq stays low", {31'b0, irq_out}, 32'h0);
        // R1: level back at 0xff, so opening the threshold raises no IPI
        step(3'd3, 32'hff, 1'b0, 8'h0, 24'h0);
        chk("R1", "resend only", {31'b0, resend_req}, 32'h1);
        chk("R1", "no IPI from reset level", {31'b0, irq_out}, 32'h0);
        // R6: consecutive peeks identical
        step(3'd2, 32'h0, 1'b0, 8'h0, 24'h0);
        chk("R6", "peek word", rd_seen, 32'hff000000);
        step(3'd2, 32'h0, 1'b0, 8'h0, 24'h0);
        chk("R6", "second peek word", rd_seen, 32'hff000000);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule